// File: doc/BRIEF.md
# Power-up latched test-mode controller

This block decides whether a clock device runs normally or in a test mode, and which test output it drives. On the first clock edge after the power-on reset is released, it samples a strap input once. If the strap was high, the device is in strap-entered test mode. A live test pin, passed through a two-flop synchronizer, then selects between a high-impedance output and a reference-divided output.

If the strap was low, software can still enter test mode by writing 1 to an entry register bit. After that, a select register bit picks the output and the live pin has no effect. Both ways into test mode are one-shot. Once the device is in test mode, only the power-on reset brings it back to normal operation.

The controller is a four-state machine:
- `ST_SAMPLE` is the state after reset. It moves to `ST_HW_TEST` when the strap is high and to `ST_NORMAL` when the strap is low.
- `ST_NORMAL` moves to `ST_SW_TEST` once the entry bit reads 1.
- `ST_HW_TEST` and `ST_SW_TEST` hold until reset.

Top module: `tmode_ctrl`

## Requirements
- R1: While `por_ni` is low and before the first clock edge after its release, `mode_o` is 2'b00 (normal) and both register bits read back 0.
- R2: The strap is sampled only on the first rising edge after `por_ni` goes high. A 1 there enters test mode, and later changes of the strap have no effect until the next reset.
- R3: In strap-entered test mode, `mode_o` is 2'b01 (high-impedance) when the synchronized pin is 0 and 2'b10 (reference-divided) when it is 1. A pin change appears after the second rising edge that samples it.
- R4: In strap-entered test mode, writes to the entry bit and the select bit do not change `mode_o`. This holds even for a write made in the sampling cycle itself.
- R5: With the strap sampled low, a write of 1 to address 0 (the entry bit) enters test mode. `mode_o` leaves 2'b00 on the rising edge that follows the edge which stored the bit.
- R6: In software-entered test mode, the bit at address 1 (the select bit) sets `mode_o`: 0 gives 2'b01 and 1 gives 2'b10. A new value shows from the edge that stores it.
- R7: In software-entered test mode, the live test pin has no effect on `mode_o`.
- R8: Writing 0 to the entry bit after test mode was entered does not return `mode_o` to 2'b00.
- R9: With the strap sampled low and the entry bit never 1, `mode_o` stays 2'b00 whatever the select bit and the pin do.
- R10: `rd_data_o` combinationally returns the stored bit at `rd_addr_i` (0 = entry, 1 = select). It shows the stored value, not whether test mode is active.
- R11: Asserting `por_ni` low leaves any test mode, clears both bits and re-arms the strap sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| strap_i | input | 1 | Strap level, sampled once after reset |
| tpin_i | input | 1 | Live test pin, output select in strap-entered mode |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 1 | Write address: 0 entry bit, 1 select bit |
| wr_data_i | input | 1 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 1 | Stored bit at `rd_addr_i` |
| mode_o | output | 2 | 00 normal, 01 high-impedance, 10 reference-divided |

## Verification
The hardest situation to reach from the ports is a register write that lands in the single sampling cycle while the strap is high. That write stores the entry bit, yet the strap path must still win and the pin must keep control of the output. The stimulus releases reset on a falling edge and drives the entry write on that same edge, so that the first rising edge both samples the strap and stores the bit. The reference model then shows whether the select bit or the pin drives the output. Reset is also pulsed several times between scenarios so that re-sampling and clearing after each test mode are covered.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_HIZ    = 2'b01,
        MODE_REFDIV = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ST_SAMPLE,
        ST_NORMAL,
        ST_HW_TEST,
        ST_SW_TEST
    } state_e;

    // register bit addresses
    localparam int unsigned REG_ENTRY = 0;
    localparam int unsigned REG_SEL   = 1;

endpackage

// File: rtl/tmode_sync.sv
module tmode_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge por_ni) begin
                    if (!por_ni) chain_q[s] <= 1'b0;
                    else         chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge por_ni) begin
                    if (!por_ni) chain_q[s] <= 1'b0;
                    else         chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/tmode_regs.sv
module tmode_regs
    import tmode_pkg::*;
#(
    parameter int unsigned ADDR_W = 1
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_data_o,
    output logic              entry_o,
    output logic              sel_o
);
    localparam int unsigned NREGS = 1 << ADDR_W;

    logic [NREGS-1:0] bits_q;

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_bit
            always_ff @(posedge clk_i or negedge por_ni) begin
                if (!por_ni)
                    bits_q[i] <= 1'b0;
                else if (wr_en_i && (wr_addr_i == ADDR_W'(i)))
                    bits_q[i] <= wr_data_i;
            end
        end
    endgenerate

    assign rd_data_o = bits_q[rd_addr_i];
    assign entry_o   = bits_q[REG_ENTRY];
    assign sel_o     = bits_q[REG_SEL];

endmodule

// File: rtl/tmode_fsm.sv
module tmode_fsm
    import tmode_pkg::*;
(
    input  logic  clk_i,
    input  logic  por_ni,
    input  logic  strap_i,
    input  logic  entry_i,
    input  logic  sel_i,
    input  logic  pin_i,
    output mode_e mode_o,
    output logic  hw_active_o,
    output logic  sw_active_o,
    output logic  sampled_o
);
    state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) state_q <= ST_SAMPLE;
        else         state_q <= state_d;
    end

    // transitions: only reset leaves the test states
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE:  state_d = strap_i ? ST_HW_TEST : ST_NORMAL;
            ST_NORMAL:  if (entry_i) state_d = ST_SW_TEST;
            ST_HW_TEST: state_d = ST_HW_TEST;
            ST_SW_TEST: state_d = ST_SW_TEST;
        endcase
    end

    // outputs
    always_comb begin
        mode_o      = MODE_NORMAL;
        hw_active_o = 1'b0;
        sw_active_o = 1'b0;
        sampled_o   = 1'b1;
        unique case (state_q)
            ST_SAMPLE:  sampled_o = 1'b0;
            ST_NORMAL:  mode_o = MODE_NORMAL;
            ST_HW_TEST: begin
                hw_active_o = 1'b1;
                mode_o      = pin_i ? MODE_REFDIV : MODE_HIZ;
            end
            ST_SW_TEST: begin
                sw_active_o = 1'b1;
                mode_o      = sel_i ? MODE_REFDIV : MODE_HIZ;
            end
        endcase
    end

endmodule

// File: rtl/tmode_ctrl.sv
module tmode_ctrl
    import tmode_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 1
) (
    input  logic              clk_i,
    input  logic              por_ni,
    input  logic              strap_i,
    input  logic              tpin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_data_o,
    output logic [1:0]        mode_o
);
    logic  pin_sync;
    logic  entry_bit;
    logic  sel_bit;
    logic  hw_active;
    logic  sw_active;
    logic  sampled;
    mode_e mode_w;

    tmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .por_ni (por_ni),
        .d_i    (tpin_i),
        .q_o    (pin_sync)
    );

    tmode_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i     (clk_i),
        .por_ni    (por_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .entry_o   (entry_bit),
        .sel_o     (sel_bit)
    );

    tmode_fsm u_fsm (
        .clk_i       (clk_i),
        .por_ni      (por_ni),
        .strap_i     (strap_i),
        .entry_i     (entry_bit),
        .sel_i       (sel_bit),
        .pin_i       (pin_sync),
        .mode_o      (mode_w),
        .hw_active_o (hw_active),
        .sw_active_o (sw_active),
        .sampled_o   (sampled)
    );

    assign mode_o = mode_w;

endmodule

// File: rtl/tmode_chk.sv
module tmode_chk #(
    parameter int unsigned ADDR_W = 1
) (
    input logic              clk_i,
    input logic              por_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              wr_data_i,
    input logic [1:0]        mode_o,
    input logic              hw_active,
    input logic              sw_active,
    input logic              sampled,
    input logic              entry_bit
);
    localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(1);

    AST_HW_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
        hw_active |=> hw_active); // R2

    AST_SW_ENTRY: assert property (@(posedge clk_i) disable iff (!por_ni)
        (sampled && !hw_active && entry_bit) |=> sw_active); // R5

    AST_SW_SELECT: assert property (@(posedge clk_i) disable iff (!por_ni)
        (sw_active && wr_en_i && wr_addr_i == A_SEL)
        |=> (mode_o == ($past(wr_data_i) ? 2'b10 : 2'b01))); // R6

    AST_TEST_HOLDS: assert property (@(posedge clk_i) disable iff (!por_ni)
        (mode_o != 2'b00) |=> (mode_o != 2'b00)); // R8

    AST_IDLE_NORMAL: assert property (@(posedge clk_i) disable iff (!por_ni)
        (!hw_active && !sw_active) |-> (mode_o == 2'b00)); // R9

    AST_ENTRY_STORED: assert property (@(posedge clk_i) disable iff (!por_ni)
        (wr_en_i && wr_addr_i == A_ENTRY) |=> (entry_bit == $past(wr_data_i))); // R10

endmodule

bind tmode_ctrl tmode_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_o),
    .hw_active (hw_active),
    .sw_active (sw_active),
    .sampled   (sampled),
    .entry_bit (entry_bit)
);

// File: tb/tb_tmode_ctrl.sv
module tb_tmode_ctrl;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       por_n   = 1'b0;
    logic       strap   = 1'b0;
    logic       tpin    = 1'b0;
    logic       wr_en   = 1'b0;
    logic       wr_addr = 1'b0;
    logic       wr_data = 1'b0;
    logic       rd_addr = 1'b0;
    logic       rd_data;
    logic [1:0] mode;

    tmode_ctrl dut (
        .clk_i     (clk),
        .por_ni    (por_n),
        .strap_i   (strap),
        .tpin_i    (tpin),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .mode_o    (mode)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model: phase 0 unsampled, 1 normal, 2 strap test, 3 software test
    int m_phase = 0;
    int m_entry = 0;
    int m_sel   = 0;
    int pin_q[$];

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_phase = 0;
            m_entry = 0;
            m_sel   = 0;
            pin_q.delete();
        end else begin
            pin_q.push_back(int'(tpin));
            if (pin_q.size() > 2) void'(pin_q.pop_front());
            if (m_phase == 0)                       m_phase = strap ? 2 : 1;
            else if (m_phase == 1 && m_entry == 1)  m_phase = 3;
            if (wr_en) begin
                if (wr_addr) m_sel   = int'(wr_data);
                else         m_entry = int'(wr_data);
            end
        end
    end

    function automatic int exp_mode();
        int synced = (pin_q.size() == 2) ? pin_q[0] : 0;
        case (m_phase)
            2:       return synced ? 2 : 1;
            3:       return m_sel ? 2 : 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            case (m_phase)
                0:       check(int'(mode), exp_mode(), "R1 mode per-cycle");
                1:       check(int'(mode), exp_mode(), "R9 mode per-cycle");
                2:       check(int'(mode), exp_mode(), "R3 mode per-cycle");
                default: check(int'(mode), exp_mode(), "R6 mode per-cycle");
            endcase
            check(int'(rd_data), rd_addr ? m_sel : m_entry, "R10 readback per-cycle");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic a, input logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #2;
    endtask

    task automatic por_cycle(input logic s);
        @(negedge clk);
        por_n = 1'b0;
        strap = s;
        #2;
        check(int'(mode), 0, "R11 mode during reset");
        check(int'(rd_data), 0, "R1 readback during reset");
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        #2;
        check(int'(mode), 0, "R1 reset mode");

        // strap high: pin-driven test mode
        tpin = 1'b0;
        por_cycle(1'b1);
        step(3);
        check(int'(mode), 1, "R2 strap high enters test");
        tpin = 1'b1;
        step(1);
        check(int'(mode), 1, "R3 pin not yet through synchronizer");
        step(1);
        check(int'(mode), 2, "R3 pin high selects refdiv");
        strap = 1'b0;
        step(3);
        check(int'(mode), 2, "R2 later strap change ignored");
        wr(1'b0, 1'b1);
        wr(1'b1, 1'b0);
        step(2);
        check(int'(mode), 2, "R4 register writes ignored");
        rd_addr = 1'b0;
        #1;
        check(int'(rd_data), 1, "R10 entry bit stored");
        tpin = 1'b0;
        step(3);
        check(int'(mode), 1, "R3 pin low selects hiz");

        // strap low: normal until software entry
        por_cycle(1'b0);
        step(3);
        check(int'(mode), 0, "R11 reset leaves test mode");
        tpin = 1'b1;
        wr(1'b1, 1'b1);
        step(3);
        check(int'(mode), 0, "R9 normal despite select and pin");
        rd_addr = 1'b1;
        #1;
        check(int'(rd_data), 1, "R10 select bit stored");
        wr(1'b0, 1'b1);
        check(int'(mode), 0, "R5 entry not yet applied");
        step(1);
        check(int'(mode), 2, "R5 software entry takes effect");
        wr(1'b1, 1'b0);
        check(int'(mode), 1, "R6 select 0 gives hiz");
        wr(1'b1, 1'b1);
        check(int'(mode), 2, "R6 select 1 gives refdiv");
        tpin = 1'b0;
        step(4);
        check(int'(mode), 2, "R7 pin ignored in software mode");
        tpin = 1'b1;
        step(4);
        check(int'(mode), 2, "R7 pin ignored again");
        wr(1'b0, 1'b0);
        step(3);
        check(int'(mode), 2, "R8 clearing entry keeps test");
        rd_addr = 1'b0;
        #1;
        check(int'(rd_data), 0, "R8 entry reads back 0");

        // corner: entry write in the sampling cycle with strap high
        @(negedge clk);
        por_n = 1'b0; strap = 1'b1; tpin = 1'b1;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        step(3);
        check(int'(mode), 2, "R4 sampling-cycle write, pin still rules");
        tpin = 1'b0;
        step(3);
        check(int'(mode), 1, "R4 pin low still followed");

        // strap low, raised after sampling
        por_cycle(1'b0);
        step(1);
        strap = 1'b1;
        step(6);
        check(int'(mode), 0, "R2 strap raised after sampling ignored");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule